// File: doc/BRIEF.md
# Floating-Point Register File with Load/Store Format Conversion

This block is the operand store for a floating-point datapath. It holds 32 registers. A parameter fixes their width: 64 bits when the file keeps double precision, 32 bits when it keeps single precision. The arithmetic pipeline reaches the registers through two combinational read ports and one clocked write port.

A separate 128-bit memory side moves one operand per clock. Loads write a register and the store port reads one combinationally. Each transfer names its memory format, single or double, on its own. When that format differs from the register precision, the block converts the value bit by bit on the way in or out.

The conversion copies the sign and rebiases the exponent. It truncates or zero-pads the fraction, with no rounding and no renormalization. Zero and all-ones exponents keep their class, so zeros, subnormal patterns, infinities and NaNs are preserved.

Top module: `fp_regfile_conv`

## Requirements
- R1: The file has 32 registers, each 64 bits wide when `DBL_REGS`=1 and 32 bits wide when `DBL_REGS`=0. Synchronous active-low reset clears every register to zero.
- R2: When `ld_valid` is high, register `ld_addr` takes the converted load word at the next rising edge. A single-format word is taken from `ld_data[127:96]` and a double-format word from `ld_data[127:64]`. The remaining lanes are ignored. When `ld_valid` is low, no register changes because of the load port.
- R3: `st_data` is combinational from register `st_addr`. A double-format store places the word in `[127:64]` with `[63:0]` zero. A single-format store places it in `[127:96]` with `[95:0]` zero.
- R4: Narrowing (double to single) copies the sign, keeps the top 23 fraction bits (bits 51..29 of the double word) and drops the rest without rounding. In the MSB-first layout, bit 63 is the sign, bits 62..52 the exponent and 51..0 the fraction for double. For single, bit 31 is the sign, 30..23 the exponent and 22..0 the fraction.
- R5: Widening (single to double) copies the sign and appends 29 zero bits below the 23-bit fraction. No renormalization is done, so subnormal fractions keep their bit pattern.
- R6: When converting, an exponent of zero maps to zero and an all-ones exponent maps to all-ones. Any other single exponent e becomes e+896. Any other double exponent e becomes the low 8 bits of e-896, and out-of-range values wrap without a flag.
- R7: `rd_a_data` and `rd_b_data` are combinational reads of `rd_a_addr` and `rd_b_addr`. `wr_en` writes `wr_data` into `wr_addr` at the next rising edge. A load and a datapath write to different registers in one cycle both take effect.
- R8: A read on either read port or on the store port of a register written in the same cycle returns the value being written. This holds for a datapath write and for a load.
- R9: When a load and a datapath write target the same register in one cycle, the datapath write is the one that lands and the one that is bypassed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_valid | input | 1 | Load transfer valid |
| ld_is_double | input | 1 | Load memory format: 1 double, 0 single |
| ld_addr | input | 5 | Load destination register |
| ld_data | input | 128 | Load data, operand in the most significant lane |
| st_addr | input | 5 | Store source register |
| st_is_double | input | 1 | Store memory format: 1 double, 0 single |
| st_data | output | 128 | Store data, operand in the most significant lane, rest zero |
| rd_a_addr | input | 5 | Read port A register |
| rd_b_addr | input | 5 | Read port B register |
| rd_a_data | output | 32 or 64 | Read port A value |
| rd_b_data | output | 32 or 64 | Read port B value |
| wr_en | input | 1 | Datapath write enable |
| wr_addr | input | 5 | Datapath write register |
| wr_data | input | 32 or 64 | Datapath write value |

## Verification
The bench checks that converted exponents of infinities, NaNs, signed zeros and subnormal patterns stay at all-ones or zero. A design that rebiased these unconditionally would turn a NaN into a finite number. A double value whose low fraction bits are all ones is narrowed and compared with plain truncation, which catches a design that rounds. A smallest-normal and a large-exponent double are narrowed to expose the wrap-around of the 8-bit exponent.

The bench issues same-cycle reads of a register being written, including a load and a datapath write that collide on one address. A design without write-first bypass, or with the wrong write priority, returns the stale or the losing value. Garbage in the unused load lanes shows a design that picks the wrong lane.

// File: rtl/fprf_pkg.sv
package fprf_pkg;
  localparam int NUM_REGS   = 32;
  localparam int ADDR_W     = 5;
  localparam int XFER_W     = 128;
  localparam int SGL_W      = 32;
  localparam int DBL_W      = 64;
  localparam int SGL_EXP_W  = 8;
  localparam int DBL_EXP_W  = 11;
  localparam int SGL_FRAC_W = 23;
  localparam int DBL_FRAC_W = 52;
  localparam int FRAC_DROP  = DBL_FRAC_W - SGL_FRAC_W;
  localparam int BIAS_DELTA = 1023 - 127;

  // double word -> single word, fraction truncated, exponent rebiased
  function automatic logic [SGL_W-1:0] f_narrow(input logic [DBL_W-1:0] d);
    logic [DBL_EXP_W-1:0] e;
    logic [DBL_EXP_W-1:0] t;
    logic [SGL_EXP_W-1:0] n;
    e = d[DBL_W-2 -: DBL_EXP_W];
    t = e - DBL_EXP_W'(BIAS_DELTA);
    if (e == '0)      n = '0;
    else if (&e)      n = '1;
    else              n = t[SGL_EXP_W-1:0];
    return {d[DBL_W-1], n, d[DBL_FRAC_W-1 -: SGL_FRAC_W]};
  endfunction

  // single word -> double word, fraction zero padded, exponent rebiased
  function automatic logic [DBL_W-1:0] f_widen(input logic [SGL_W-1:0] s);
    logic [SGL_EXP_W-1:0] e;
    logic [DBL_EXP_W-1:0] w;
    e = s[SGL_W-2 -: SGL_EXP_W];
    if (e == '0)      w = '0;
    else if (&e)      w = '1;
    else              w = DBL_EXP_W'(e) + DBL_EXP_W'(BIAS_DELTA);
    return {s[SGL_W-1], w, s[SGL_FRAC_W-1:0], {FRAC_DROP{1'b0}}};
  endfunction
endpackage

// File: rtl/fprf_ld_conv.sv
module fprf_ld_conv
  import fprf_pkg::*;
#(
  parameter bit DBL_REGS = 1'b1,
  localparam int W = DBL_REGS ? DBL_W : SGL_W
)(
  input  logic [XFER_W-1:0] xfer,
  input  logic              is_double,
  output logic [W-1:0]      word
);
  logic [DBL_W-1:0] dbl_lane;
  logic [SGL_W-1:0] sgl_lane;
  assign dbl_lane = xfer[XFER_W-1 -: DBL_W];
  assign sgl_lane = xfer[XFER_W-1 -: SGL_W];

  generate
    if (DBL_REGS) begin : g_dbl
      assign word = is_double ? dbl_lane : f_widen(sgl_lane);
    end else begin : g_sgl
      assign word = is_double ? f_narrow(dbl_lane) : sgl_lane;
    end
  endgenerate
endmodule

// File: rtl/fprf_st_conv.sv
module fprf_st_conv
  import fprf_pkg::*;
#(
  parameter bit DBL_REGS = 1'b1,
  localparam int W = DBL_REGS ? DBL_W : SGL_W
)(
  input  logic [W-1:0]      word,
  input  logic              is_double,
  output logic [XFER_W-1:0] xfer
);
  logic [DBL_W-1:0] as_dbl;
  logic [SGL_W-1:0] as_sgl;

  generate
    if (DBL_REGS) begin : g_dbl
      assign as_dbl = word;
      assign as_sgl = f_narrow(word);
    end else begin : g_sgl
      assign as_dbl = f_widen(word);
      assign as_sgl = word;
    end
  endgenerate

  assign xfer = is_double ? {as_dbl, {(XFER_W-DBL_W){1'b0}}}
                          : {as_sgl, {(XFER_W-SGL_W){1'b0}}};
endmodule

// File: rtl/fprf_array.sv
// Storage with NWR write ports (lower index wins on a clash) and NRD
// write-first read ports.
module fprf_array #(
  parameter int W   = 64,
  parameter int N   = 32,
  parameter int NWR = 2,
  parameter int NRD = 3,
  localparam int AW = $clog2(N)
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NWR-1:0]           we,
  input  logic [NWR-1:0][AW-1:0]   waddr,
  input  logic [NWR-1:0][W-1:0]    wdata,
  input  logic [NRD-1:0][AW-1:0]   raddr,
  output logic [NRD-1:0][W-1:0]    rdata
);
  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else begin
      for (int j = NWR-1; j >= 0; j--)
        if (we[j]) mem[waddr[j]] <= wdata[j];
    end
  end

  generate
    for (genvar r = 0; r < NRD; r++) begin : g_rd
      always_comb begin
        rdata[r] = mem[raddr[r]];
        for (int j = NWR-1; j >= 0; j--)
          if (we[j] && waddr[j] == raddr[r]) rdata[r] = wdata[j];
      end
    end
  endgenerate
endmodule

// File: rtl/fp_regfile_conv.sv
module fp_regfile_conv
  import fprf_pkg::*;
#(
  parameter bit DBL_REGS = 1'b1,
  localparam int W = DBL_REGS ? DBL_W : SGL_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic              ld_is_double,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [XFER_W-1:0] ld_data,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              st_is_double,
  output logic [XFER_W-1:0] st_data,
  input  logic [ADDR_W-1:0] rd_a_addr,
  input  logic [ADDR_W-1:0] rd_b_addr,
  output logic [W-1:0]      rd_a_data,
  output logic [W-1:0]      rd_b_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data
);
  localparam int NWR = 2;   // 0: datapath (priority), 1: load
  localparam int NRD = 3;   // 0: A, 1: B, 2: store

  // named internal events
  logic [W-1:0] ld_word;    // load operand after conversion
  logic [W-1:0] st_word;    // register value feeding the store converter
  logic         wr_ld_clash;

  logic [NWR-1:0]             we;
  logic [NWR-1:0][ADDR_W-1:0] waddr;
  logic [NWR-1:0][W-1:0]      wdata;
  logic [NRD-1:0][ADDR_W-1:0] raddr;
  logic [NRD-1:0][W-1:0]      rdata;

  assign wr_ld_clash = wr_en && ld_valid && (wr_addr == ld_addr);

  fprf_ld_conv #(.DBL_REGS(DBL_REGS)) u_ld_conv (
    .xfer(ld_data), .is_double(ld_is_double), .word(ld_word)
  );

  assign we    = {ld_valid, wr_en};
  assign waddr = {ld_addr, wr_addr};
  assign wdata = {ld_word, wr_data};
  assign raddr = {st_addr, rd_b_addr, rd_a_addr};

  fprf_array #(.W(W), .N(NUM_REGS), .NWR(NWR), .NRD(NRD)) u_array (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata)
  );

  assign rd_a_data = rdata[0];
  assign rd_b_data = rdata[1];
  assign st_word   = rdata[2];

  fprf_st_conv #(.DBL_REGS(DBL_REGS)) u_st_conv (
    .word(st_word), .is_double(st_is_double), .xfer(st_data)
  );
endmodule

// File: rtl/fprf_checker.sv
module fprf_checker
  import fprf_pkg::*;
#(
  parameter bit DBL_REGS = 1'b1,
  localparam int W = DBL_REGS ? DBL_W : SGL_W
)(
  input logic              clk,
  input logic              rst_n,
  input logic              ld_valid,
  input logic              ld_is_double,
  input logic [ADDR_W-1:0] ld_addr,
  input logic [XFER_W-1:0] ld_data,
  input logic [W-1:0]      ld_word,
  input logic              st_is_double,
  input logic [XFER_W-1:0] st_data,
  input logic [ADDR_W-1:0] rd_a_addr,
  input logic [W-1:0]      rd_a_data,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [W-1:0]      wr_data,
  input logic              wr_ld_clash
);
  // R3: unused store lanes are zero
  a_r3_dbl_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
    st_is_double |-> st_data[XFER_W-DBL_W-1:0] == '0);
  a_r3_sgl_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !st_is_double |-> st_data[XFER_W-SGL_W-1:0] == '0);

  // R4: sign bit survives any load conversion
  a_r4_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> ld_word[W-1] == ld_data[XFER_W-1]);

  // R7: a datapath write is visible on the next cycle when nothing else writes
  a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_a_addr == wr_addr) ##1 ($stable(rd_a_addr) && !wr_en && !ld_valid)
      |-> rd_a_data == $past(wr_data));

  // R9: datapath write wins a same-address collision, also on the bypass
  a_r9_wr_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ld_clash && rd_a_addr == wr_addr) |-> rd_a_data == wr_data);

  generate
    if (DBL_REGS) begin : g_dbl
      // R5: widened fraction has 29 zero low bits
      a_r5_widen_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !ld_is_double) |-> ld_word[FRAC_DROP-1:0] == '0);
      // R6: all-ones single exponent stays all-ones
      a_r6_special_exp: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !ld_is_double && (&ld_data[126:119])) |-> (&ld_word[62:52]));
    end else begin : g_sgl
      // R6: all-ones double exponent stays all-ones
      a_r6_special_exp: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_is_double && (&ld_data[126:116])) |-> (&ld_word[30:23]));
    end
  endgenerate
endmodule

bind fp_regfile_conv fprf_checker #(.DBL_REGS(DBL_REGS)) u_fprf_checker (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_is_double(ld_is_double),
  .ld_addr(ld_addr), .ld_data(ld_data), .ld_word(ld_word),
  .st_is_double(st_is_double), .st_data(st_data),
  .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .wr_ld_clash(wr_ld_clash)
);

// File: tb/tb_fp_regfile_conv.sv
`timescale 1ns/1ps
module tb_fp_regfile_conv;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ld_valid = 1'b0, ld_is_double = 1'b0;
  logic [4:0]   ld_addr = '0, st_addr = '0, rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
  logic [127:0] ld_data = '0;
  logic         st_is_double = 1'b0, wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [127:0] st_data;
  logic [W-1:0] rd_a_data, rd_b_data;

  always #2.5 clk = ~clk;

  fp_regfile_conv #(.DBL_REGS(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_is_double(ld_is_double),
    .ld_addr(ld_addr), .ld_data(ld_data), .st_addr(st_addr),
    .st_is_double(st_is_double), .st_data(st_data), .rd_a_addr(rd_a_addr),
    .rd_b_addr(rd_b_addr), .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  typedef struct {
    int           kind;   // 0 port A, 1 port B, 2 store
    logic [127:0] exp;
    string        tag;
  } item_t;
  item_t sb[$];
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // reference conversions written from the requirements
  function automatic logic [31:0] ref_narrow(input logic [63:0] d);
    int unsigned ex;
    logic [31:0] r;
    ex = int'(d[62:52]);
    if (ex == 0)          r = 32'd0;
    else if (ex == 2047)  r = 32'd255;
    else                  r = 32'(ex + 127 - 1023);
    return {d[63], r[7:0], d[51:29]};
  endfunction

  function automatic logic [63:0] ref_widen(input logic [31:0] s);
    int unsigned ex;
    logic [31:0] r;
    ex = int'(s[30:23]);
    if (ex == 0)         r = 32'd0;
    else if (ex == 255)  r = 32'd2047;
    else                 r = 32'(ex - 127 + 1023);
    return {s[31], r[10:0], s[22:0], 29'd0};
  endfunction

  task automatic step(input logic lv, input logic ldbl, input logic [4:0] la,
                      input logic [127:0] ld, input logic we, input logic [4:0] wa,
                      input logic [63:0] wd, input logic [4:0] ra, input logic [4:0] rb,
                      input logic [4:0] sa, input logic sdbl);
    @(negedge clk);
    ld_valid = lv; ld_is_double = ldbl; ld_addr = la; ld_data = ld;
    wr_en = we; wr_addr = wa; wr_data = wd;
    rd_a_addr = ra; rd_b_addr = rb; st_addr = sa; st_is_double = sdbl;
  endtask

  task automatic expect_item(input int kind, input logic [127:0] e, input string tag);
    item_t it;
    it.kind = kind; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: compares queued items mid-cycle, before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        logic [127:0] act;
        it = sb.pop_front();
        case (it.kind)
          0:       act = {64'd0, rd_a_data};
          1:       act = {64'd0, rd_b_data};
          default: act = st_data;
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  localparam logic [63:0] ONE_D  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] TRUNC  = 64'h3FF0_0000_3FFF_FFFF;
  localparam logic [31:0] NEG_S  = 32'hC020_0000;

  initial begin
    logic [63:0] dspec [6];
    logic [31:0] sspec [4];
    dspec = '{64'h7FF0_0000_0000_0000, 64'h7FF8_0000_0000_0001, 64'h8000_0000_0000_0000,
              64'h000F_FFFF_FFFF_FFFF, 64'h5000_0000_0000_0000, 64'h0010_0000_0000_0000};
    sspec = '{32'h7F80_0000, 32'h0000_0001, 32'hFF80_0000, 32'h3F80_0000};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset clears the file
    step(0,0,0,'0, 0,0,'0, 0,31, 5,1);
    expect_item(0, 128'd0, "R1");
    expect_item(1, 128'd0, "R1");
    expect_item(2, 128'd0, "R1");

    // R2/R8: double load with junk in unused lanes, same-cycle read bypass
    step(1,1,1,{ONE_D, 64'hDEAD_BEEF_0123_4567}, 0,0,'0, 1,2, 1,1);
    expect_item(0, {64'd0, ONE_D}, "R8");
    expect_item(1, 128'd0, "R2");
    expect_item(2, {ONE_D, 64'd0}, "R8");

    // R2/R3: stored value read back in double format
    step(0,0,0,'0, 0,0,'0, 1,0, 1,1);
    expect_item(0, {64'd0, ONE_D}, "R2");
    expect_item(2, {ONE_D, 64'd0}, "R3");

    // R4: store as single narrows
    step(0,0,0,'0, 0,0,'0, 1,0, 1,0);
    expect_item(2, {ref_narrow(ONE_D), 96'd0}, "R4");

    // R5: single load widens, junk in low lanes ignored
    step(1,0,2,{NEG_S, {96{1'b1}}}, 0,0,'0, 0,0, 0,1);
    step(0,0,0,'0, 0,0,'0, 0,2, 2,0);
    expect_item(1, {64'd0, ref_widen(NEG_S)}, "R5");
    expect_item(2, {NEG_S, 96'd0}, "R5");

    // R4: truncation without rounding
    step(1,1,3,{TRUNC, 64'd0}, 0,0,'0, 0,0, 0,1);
    step(0,0,0,'0, 0,0,'0, 3,0, 3,0);
    expect_item(0, {64'd0, TRUNC}, "R2");
    expect_item(2, {ref_narrow(TRUNC), 96'd0}, "R4");

    // R6: special and out-of-range exponents when narrowing
    for (int k = 0; k < 6; k++) begin
      step(1,1,5'(10+k),{dspec[k], 64'd0}, 0,0,'0, 0,0, 0,1);
      step(0,0,0,'0, 0,0,'0, 0,0, 5'(10+k),0);
      expect_item(2, {ref_narrow(dspec[k]), 96'd0}, "R6");
    end

    // R6/R5: special exponents and subnormal when widening
    for (int k = 0; k < 4; k++) begin
      step(1,0,5'(20+k),{sspec[k], 96'd0}, 0,0,'0, 0,0, 0,1);
      step(0,0,0,'0, 0,0,'0, 0,5'(20+k), 0,1);
      expect_item(1, {64'd0, ref_widen(sspec[k])}, "R6");
    end

    // R8: datapath write bypass on port A and store port
    step(0,0,0,'0, 1,4,64'h4000_0000_0000_0000, 4,0, 4,1);
    expect_item(0, {64'd0, 64'h4000_0000_0000_0000}, "R8");
    expect_item(2, {64'h4000_0000_0000_0000, 64'd0}, "R8");
    step(0,0,0,'0, 0,0,'0, 0,4, 0,1);
    expect_item(1, {64'd0, 64'h4000_0000_0000_0000}, "R7");

    // R7: wr_en low leaves register unchanged
    step(0,0,0,'0, 0,4,64'h1234_5678_9ABC_DEF0, 0,0, 0,1);
    step(0,0,0,'0, 0,0,'0, 4,0, 0,1);
    expect_item(0, {64'd0, 64'h4000_0000_0000_0000}, "R7");

    // R2: ld_valid low leaves register unchanged
    step(0,1,1,{64'hC000_0000_0000_0000, 64'd0}, 0,0,'0, 0,0, 0,1);
    step(0,0,0,'0, 0,0,'0, 1,0, 0,1);
    expect_item(0, {64'd0, ONE_D}, "R2");

    // R9: collision, datapath write wins (bypass and stored)
    step(1,1,5,{64'hAAAA_0000_0000_0000, 64'd0}, 1,5,64'h5555_0000_0000_0000, 5,0, 0,1);
    expect_item(0, {64'd0, 64'h5555_0000_0000_0000}, "R9");
    step(0,0,0,'0, 0,0,'0, 5,0, 0,1);
    expect_item(0, {64'd0, 64'h5555_0000_0000_0000}, "R9");

    // R7: load and datapath write to different registers both land
    step(1,1,6,{64'h3FF8_0000_0000_0000, 64'd0}, 1,7,64'hBFF0_0000_0000_0000, 0,0, 0,1);
    step(0,0,0,'0, 0,0,'0, 6,7, 0,1);
    expect_item(0, {64'd0, 64'h3FF8_0000_0000_0000}, "R7");
    expect_item(1, {64'd0, 64'hBFF0_0000_0000_0000}, "R7");

    step(0,0,0,'0, 0,0,'0, 0,0, 0,1);
    @(negedge clk);
    #2;
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule